// File: doc/BRIEF.md
# Host Command Dispatcher for SPI and I2C

The block takes command bytes from a host-side byte buffer and forwards each command packet to a serial output. The buffer offers a byte with a valid flag, and the dispatcher takes it in any cycle where it raises its ready output. A packet has three parts. A selector byte comes first. A length byte follows it. After those come the payload bytes. Bit 0 of the selector picks the protocol. Bit 1 picks which of two SPI targets receives the chip select.

SPI payload is shifted out by an internal mode-0 transmitter. It sends the most significant bit first. Its bit clock is derived from the system clock, at a quarter of its rate. I2C payload is handed byte by byte to an external I2C bit engine over a valid/ready pair. The block also supplies that engine's bit-rate enable, a single-cycle pulse once every eighty system clocks. The dispatcher stalls whenever the buffer runs empty and never aborts a packet. It looks for a new selector only after the previous packet has fully left the block.

Top module: `cmd_dispatch`

## Requirements
- R1: A selector with bit 0 = 0 sends every payload byte out on SPI, MSB first, in mode 0. The clock idles low, and MOSI is stable while SCLK is high, so a target samples on the rising edge.
- R2: A selector with bit 0 = 1 sends the payload bytes, in order, on `i2c_data_o` by valid/ready handshakes. During the packet both chip selects stay high and SCLK stays low.
- R3: For an SPI packet, selector bit 1 = 0 drives `spi_cs_n_o[0]` low and bit 1 = 1 drives `spi_cs_n_o[1]` low. The other chip select stays high for the whole packet, and at most one is ever low.
- R4: The second byte of a packet gives the payload count N. Values 1 to 255 mean N bytes, and 0 means 256 bytes. Exactly N bytes are consumed as payload, and the byte after them is read as a new selector.
- R5: Within a byte, SCLK is high for SPI_DIV/2 cycles and low for SPI_DIV/2 cycles. Rising edges are SPI_DIV cycles apart, which is 8 MHz from a 32 MHz clock with the default of 4.
- R6: `i2c_tick_o` is a single-cycle pulse that repeats every I2C_DIV cycles, which is 400 kHz from 32 MHz with the default of 80.
- R7: The selected chip select goes low before the first SCLK rising edge of the packet. It returns high only after the last payload bit, and no sooner than SPI_DIV cycles after the final SCLK falling edge.
- R8: An empty buffer in the middle of a packet pauses output without losing or repeating bytes. The chip select stays low across the pause, giving one low window per SPI packet, and SCLK rests low between bytes.
- R9: After the last payload byte is taken, `in_ready_o` stays low until the packet completes. For SPI that is when the chip select rises. For I2C it is when the last byte is handed over.
- R10: While `i2c_valid_o` is high and `i2c_ready_i` is low, `i2c_valid_o` stays high and `i2c_data_o` holds its value.
- R11: In reset, `in_ready_o` is high, both chip selects are high, SCLK is low and `i2c_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (32 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Buffer holds a byte |
| in_data_i | input | 8 | Byte at the buffer head |
| in_ready_o | output | 1 | Byte at the head is taken this cycle when valid |
| spi_sclk_o | output | 1 | SPI clock, mode 0 |
| spi_mosi_o | output | 1 | SPI serial data, MSB first |
| spi_cs_n_o | output | 2 | Active-low chip selects, one per target |
| i2c_valid_o | output | 1 | Byte on `i2c_data_o` is ready for the I2C engine |
| i2c_data_o | output | 8 | Payload byte for the I2C engine |
| i2c_ready_i | input | 1 | I2C engine takes the offered byte |
| i2c_tick_o | output | 1 | I2C bit-rate enable pulse |

## Verification
A parser that counts the length wrongly, or that mistakes the 0 = 256 case, pushes every later packet out of step. The first symptom is a wrong protocol or a wrong target on the byte right after the short or long packet, and every later byte stays misaligned. A wrong chip-select decode or release shows on the first SCLK rising edge of the packet, or on the release edge itself. A shifter that is off by one corrupts the first byte it sends. A divider error shows as wrong spacing between the second rising edge of a byte and the one before it, or between two I2C ticks in a row.

// File: rtl/cmd_dispatch_pkg.sv
package cmd_dispatch_pkg;
  typedef enum logic [1:0] {
    ST_SEL  = 2'd0,
    ST_LEN  = 2'd1,
    ST_DATA = 2'd2,
    ST_TAIL = 2'd3
  } disp_state_e;

  localparam int SEL_PROTO_BIT = 0;  // 1 = I2C
  localparam int SEL_TGT_LSB   = 1;
endpackage

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_o <= 1'b0;
    end
  end

  if (DIV > 1) begin : g_chk
    assert_tick_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         half_tick_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic         busy_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      sclk_o <= 1'b0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= data_i;
      bit_q  <= '0;
      sclk_o <= 1'b0;
      busy_o <= 1'b1;
    end else if (busy_o && half_tick_i) begin
      if (!sclk_o) begin
        sclk_o <= 1'b1;
      end else begin
        sclk_o <= 1'b0;
        if (bit_q == LAST) begin
          busy_o <= 1'b0;
        end else begin
          bit_q <= bit_q + CW'(1);
          sh_q  <= {sh_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign mosi_o = sh_q[W-1];

  assert_mosi_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_dispatch_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_CS  = 2,
  parameter int SPI_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DW-1:0]     in_data_i,
  output logic              in_ready_o,
  output logic              spi_load_o,
  output logic [DW-1:0]     spi_data_o,
  input  logic              spi_busy_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              i2c_valid_o,
  output logic [DW-1:0]     i2c_data_o,
  input  logic              i2c_ready_i
);
  localparam int LEN_W = DW + 1;
  localparam int TGT_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int GW    = $clog2(SPI_DIV);
  localparam logic [GW-1:0] GLAST = GW'(SPI_DIV - 1);

  disp_state_e      state_q;
  logic             i2c_q;
  logic [TGT_W-1:0] tgt_q;
  logic [LEN_W-1:0] rem_q;
  logic [GW-1:0]    guard_q;
  logic             accept;
  logic             spi_on;

  always_comb begin
    unique case (state_q)
      ST_SEL, ST_LEN: in_ready_o = 1'b1;
      ST_DATA:        in_ready_o = i2c_q ? !i2c_valid_o : !spi_busy_i;
      default:        in_ready_o = 1'b0;
    endcase
  end

  assign accept     = in_valid_i && in_ready_o;
  assign spi_load_o = accept && (state_q == ST_DATA) && !i2c_q;
  assign spi_data_o = in_data_i;
  assign spi_on     = !i2c_q && ((state_q == ST_DATA) || (state_q == ST_TAIL));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = !(spi_on && (tgt_q == TGT_W'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEL;
      i2c_q   <= 1'b0;
      tgt_q   <= '0;
      rem_q   <= '0;
      guard_q <= '0;
    end else begin
      unique case (state_q)
        ST_SEL: if (accept) begin
          i2c_q   <= in_data_i[SEL_PROTO_BIT];
          tgt_q   <= in_data_i[SEL_TGT_LSB +: TGT_W];
          state_q <= ST_LEN;
        end
        ST_LEN: if (accept) begin
          rem_q   <= (in_data_i == '0) ? LEN_W'(1 << DW) : {1'b0, in_data_i};
          state_q <= ST_DATA;
        end
        ST_DATA: if (accept) begin
          rem_q   <= rem_q - LEN_W'(1);
          guard_q <= '0;
          if (rem_q == LEN_W'(1)) state_q <= ST_TAIL;
        end
        default: begin
          if (i2c_q) begin
            if (!i2c_valid_o || i2c_ready_i) state_q <= ST_SEL;
          end else if (!spi_busy_i) begin
            // hold select one full bit period past the last falling edge
            if (guard_q == GLAST) state_q <= ST_SEL;
            else                  guard_q <= guard_q + GW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i2c_valid_o <= 1'b0;
      i2c_data_o  <= '0;
    end else if (accept && (state_q == ST_DATA) && i2c_q) begin
      i2c_valid_o <= 1'b1;
      i2c_data_o  <= in_data_i;
    end else if (i2c_ready_i) begin
      i2c_valid_o <= 1'b0;
    end
  end

  assert_cs_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  assert_i2c_no_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i2c_valid_o |-> (&cs_n_o));
  assert_i2c_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i2c_valid_o && !i2c_ready_i) |=> (i2c_valid_o && $stable(i2c_data_o)));
  assert_no_load_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_load_o |-> !spi_busy_i);
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch #(
  parameter int DW      = 8,
  parameter int NUM_CS  = 2,
  parameter int SPI_DIV = 4,
  parameter int I2C_DIV = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DW-1:0]     in_data_i,
  output logic              in_ready_o,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  output logic [NUM_CS-1:0] spi_cs_n_o,
  output logic              i2c_valid_o,
  output logic [DW-1:0]     i2c_data_o,
  input  logic              i2c_ready_i,
  output logic              i2c_tick_o
);
  localparam int SPI_HALF = SPI_DIV / 2;

  logic          spi_half_tick;
  logic          spi_load;
  logic [DW-1:0] spi_data;
  logic          spi_busy;

  clk_en_div #(.DIV(SPI_HALF)) i_spi_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (spi_half_tick)
  );

  clk_en_div #(.DIV(I2C_DIV)) i_i2c_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (i2c_tick_o)
  );

  cmd_parser #(.DW(DW), .NUM_CS(NUM_CS), .SPI_DIV(SPI_DIV)) i_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .spi_load_o  (spi_load),
    .spi_data_o  (spi_data),
    .spi_busy_i  (spi_busy),
    .cs_n_o      (spi_cs_n_o),
    .i2c_valid_o (i2c_valid_o),
    .i2c_data_o  (i2c_data_o),
    .i2c_ready_i (i2c_ready_i)
  );

  spi_tx #(.W(DW)) i_spi_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_tick_i (spi_half_tick),
    .load_i      (spi_load),
    .data_i      (spi_data),
    .sclk_o      (spi_sclk_o),
    .mosi_o      (spi_mosi_o),
    .busy_o      (spi_busy)
  );

  assert_sclk_under_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> !(&spi_cs_n_o));
endmodule

// File: tb/test_cmd_dispatch.sv
`timescale 1ns/1ps
module test_cmd_dispatch;
  localparam int SPI_DIV = 4;
  localparam int I2C_DIV = 80;
  localparam int MAXB    = 2048;
  localparam int WD      = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       in_valid = 1'b0;
  logic [7:0] in_data  = '0;
  logic       i2c_rdy  = 1'b0;
  wire        in_ready, sclk, mosi, i2c_valid, i2c_tick;
  wire [1:0]  cs_n;
  wire [7:0]  i2c_data;

  cmd_dispatch i_cmd_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_cs_n_o(cs_n),
    .i2c_valid_o(i2c_valid), .i2c_data_o(i2c_data), .i2c_ready_i(i2c_rdy),
    .i2c_tick_o(i2c_tick)
  );

  int checks = 0, fails = 0;
  logic [7:0] stream [MAXB];
  int role [MAXB];      // 0 sel, 1 len, 2 payload, 3 last payload
  int bmode [MAXB];     // 1 = I2C packet
  int bcum [MAXB];      // cumulative count of the protocol through this packet
  int n_stream = 0;
  logic [7:0] exp_spi [MAXB];
  int exp_tgt [MAXB];
  int n_spi = 0;
  logic [7:0] exp_i2c [MAXB];
  int n_i2c = 0;
  int n_spi_pkts = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // selector: bit0 = 1 for I2C, bit1 = SPI target, upper bits ignored
  task automatic add_pkt(input int i2c, input int tgt, input int len);
    logic [7:0] b;
    int base;
    base = n_stream;
    stream[n_stream] = {6'($urandom_range(0, 63)), 1'(tgt), 1'(i2c)};
    role[n_stream] = 0; n_stream++;
    stream[n_stream] = 8'(len);   // 256 wraps to 0
    role[n_stream] = 1; n_stream++;
    for (int k = 0; k < len; k++) begin
      b = 8'($urandom_range(0, 255));
      stream[n_stream] = b;
      role[n_stream] = (k == len - 1) ? 3 : 2;
      n_stream++;
      if (i2c != 0) begin exp_i2c[n_i2c] = b; n_i2c++; end
      else begin exp_spi[n_spi] = b; exp_tgt[n_spi] = tgt; n_spi++; end
    end
    for (int k = base; k < n_stream; k++) begin
      bmode[k] = i2c;
      bcum[k]  = (i2c != 0) ? n_i2c : n_spi;
    end
    if (i2c == 0) n_spi_pkts++;
  endtask

  initial begin
    int cyc, idx, rx_spi, rx_i2c, bitpos, cs_rises, ticks;
    int last_rise, last_fall, prev_tick, tail_target;
    bit acc_pend, h_pend, hold_pend, tail_pending, tail_i2c, done;
    logic prev_sclk;
    logic [1:0] prev_cs;
    logic [7:0] sh, h_data, hold_data;

    void'($urandom(32'h00c0ffee));
    add_pkt(0, 0, 1);
    add_pkt(0, 1, 3);
    add_pkt(1, 1, 2);
    add_pkt(0, 1, 256);  // length byte 0
    add_pkt(1, 0, 40);
    add_pkt(0, 0, 255);
    for (int p = 0; p < 8; p++)
      add_pkt(int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), int'($urandom_range(1, 24)));

    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R11 ready", in_ready, 1);
    chk(cs_n == 2'b11, "R11 cs", cs_n, 3);
    chk(sclk == 1'b0, "R11 sclk", sclk, 0);
    chk(i2c_valid == 1'b0, "R11 i2c_valid", i2c_valid, 0);
    rst_n = 1'b1;

    cyc = 0; idx = 0; rx_spi = 0; rx_i2c = 0; bitpos = 0; cs_rises = 0; ticks = 0;
    last_rise = 0; last_fall = -100; prev_tick = 0; tail_target = 0;
    acc_pend = 0; h_pend = 0; hold_pend = 0; tail_pending = 0; tail_i2c = 0; done = 0;
    prev_sclk = 1'b0; prev_cs = 2'b11; sh = '0; h_data = '0; hold_data = '0;

    while (!done && cyc < WD) begin
      @(negedge clk);
      cyc++;
      // byte taken at the edge just passed
      if (acc_pend) begin
        if (role[idx] == 3) begin
          tail_pending = 1; tail_i2c = (bmode[idx] != 0); tail_target = bcum[idx];
        end
        idx++;
        in_valid = 1'b0;
      end
      // SPI monitor
      if (sclk && !prev_sclk) begin
        if (bitpos > 0) chk(cyc - last_rise == SPI_DIV, "R5 rise spacing", cyc - last_rise, SPI_DIV);
        last_rise = cyc;
        if (rx_spi < n_spi)
          chk(cs_n == ~(2'b01 << exp_tgt[rx_spi]), "R3 target select", cs_n, ~(2'b01 << exp_tgt[rx_spi]));
        sh = {sh[6:0], mosi};
        bitpos++;
        if (bitpos == 8) begin
          if (rx_spi < n_spi) chk(sh == exp_spi[rx_spi], "R1 spi byte", sh, exp_spi[rx_spi]);
          else chk(1'b0, "R1 extra spi byte", sh, 0);
          rx_spi++;
          bitpos = 0;
        end
      end
      if (!sclk && prev_sclk) begin
        chk(cyc - last_rise == SPI_DIV / 2, "R5 high time", cyc - last_rise, SPI_DIV / 2);
        last_fall = cyc;
      end
      for (int i = 0; i < 2; i++) begin
        if (cs_n[i] && !prev_cs[i]) begin
          cs_rises++;
          chk(cyc - last_fall >= SPI_DIV, "R7 release guard", cyc - last_fall, SPI_DIV);
          chk(bitpos == 0 && tail_pending && !tail_i2c && rx_spi == tail_target,
              "R7 release after last bit", rx_spi, tail_target);
          if (tail_pending && !tail_i2c) tail_pending = 0;
        end
      end
      prev_sclk = sclk;
      prev_cs = cs_n;
      // I2C handshake at the edge just passed
      if (hold_pend) chk(i2c_valid && i2c_data == hold_data, "R10 hold", i2c_data, hold_data);
      if (h_pend) begin
        if (rx_i2c < n_i2c) chk(h_data == exp_i2c[rx_i2c], "R2 i2c byte", h_data, exp_i2c[rx_i2c]);
        else chk(1'b0, "R2 extra i2c byte", h_data, 0);
        chk(cs_n == 2'b11 && !sclk, "R2 spi quiet", {sclk, cs_n}, 3);
        rx_i2c++;
        if (tail_pending && tail_i2c && rx_i2c == tail_target) tail_pending = 0;
      end
      if (tail_pending) chk(!in_ready, "R9 no selector before completion", in_ready, 0);
      // I2C tick spacing
      if (i2c_tick) begin
        if (ticks > 0) chk(cyc - prev_tick == I2C_DIV, "R6 tick spacing", cyc - prev_tick, I2C_DIV);
        prev_tick = cyc;
        ticks++;
      end
      // drive next inputs; gaps create mid-packet stalls (R8)
      if (!in_valid && idx < n_stream && $urandom_range(0, 9) < 6) begin
        in_valid = 1'b1;
        in_data  = stream[idx];
      end
      i2c_rdy   = ($urandom_range(0, 3) != 0);
      acc_pend  = in_valid && in_ready;
      h_pend    = i2c_valid && i2c_rdy;
      hold_pend = i2c_valid && !i2c_rdy;
      h_data    = i2c_data;
      hold_data = i2c_data;
      if (idx == n_stream && !tail_pending && !in_valid && !i2c_valid) done = 1;
    end

    if (!done) chk(1'b0, "R4 watchdog expired", idx, n_stream);
    repeat (SPI_DIV * 4) @(negedge clk);
    chk(rx_spi == n_spi, "R4 spi byte count", rx_spi, n_spi);
    chk(rx_i2c == n_i2c, "R4 i2c byte count", rx_i2c, n_i2c);
    chk(idx == n_stream, "R4 stream consumed", idx, n_stream);
    chk(cs_rises == n_spi_pkts, "R8 one select window per packet", cs_rises, n_spi_pkts);
    chk(cs_n == 2'b11 && !sclk && in_ready, "R11 idle after traffic", {in_ready, sclk, cs_n}, 7);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule